// File: doc/BRIEF.md
# Time-Window Occupancy Trigger Generator

This block turns a stream of sampled wire data into a small set of prompt trigger bits per wire for every bunch crossing. Each wire delivers one 10-bit word per tick, and the most significant bit is the earliest sample. For every tick, two scanners look at the current word joined with the following word. They search for a run of four ones. One scanner covers runs that begin in the first half of the current word, and the other covers runs that begin in the second half.

Eleven sticky window flags per wire collect those hits over a 33-tick cycle. Which scanner feeds which window on a given tick comes from a 33-row enable table that all wires share. Each row has two enable bits per window. A row counter steps through the table, and the counter starts a programmable number of ticks after the crossing strobe.

When the cycle closes, each wire's windows are reduced to six trigger bits. Trigger bit j is the OR of the windows that a programmable 11-bit mask selects. The window flags are then cleared. The trigger bits of all wires are sent out as a burst of 16-bit words. A first-word marker, a bunch-zero marker and a half-rate data strobe travel with the words.

Top module: `tw_occ_trigger`

## Requirements
- R1: While reset is asserted and afterwards until the first frame, all outputs are zero; the enable table and the masks reset to all zeros, so a frame produced before any programming carries only zero trigger bits.
- R2: A hit for tick k is four consecutive ones in the 20-bit segment formed by word k (earlier, bit 9 first) followed by word k+1. A run starting at offsets 0 to 4 (bits 9 to 5 of word k) is an early hit. A run starting at offsets 5 to 9 (bits 4 to 0 of word k) is a late hit. Three ones in a row are not a hit.
- R3: On tick k, window i of a wire is set when (early hit and row k bit 2i) or (late hit and row k bit 2i+1). Once set, it stays set until the cycle ends.
- R4: A write with address 0 to 32 replaces table row k = address. A write with address 33 to 38 replaces the mask of trigger bit j = address - 33 with data bits 10:0. A write to addresses 39 to 63 has no effect.
- R5: Word 0 of a cycle is the word presented D clocks after the clock that samples the crossing strobe, where D is the start-delay input sampled together with that strobe.
- R6: Trigger bit j of a wire is the OR of the window flags selected by mask j. The window flags are cleared at the end of each cycle, so hits never carry into the next cycle.
- R7: The first word of a frame appears after the clock edge that samples word 33 of the cycle. Counted from the clock edge that samples the crossing strobe, that is edge number 33 + D + 1.
- R8: A frame has ceil(6*CHANNELS/16) words on consecutive clocks. Wire c, trigger j sits at bit 6c+j of the concatenated frame, and word w carries frame bits 16w+15 down to 16w. The bits past the last trigger bit are zero.
- R9: The first-word marker is high on word 0 only. The data strobe is high on even-numbered words and low on odd-numbered ones. The bunch-zero marker is high on every word of a frame whose crossing strobe came with the bunch-zero input high.
- R10: Crossings 33 ticks apart with equal delay produce two frames. The second cycle's word 0 also serves as the first cycle's word 33.
- R11: Whenever no frame word is being output, the trigger word, the first-word marker, the bunch-zero marker and the strobe are all zero.
- R12: A crossing strobe that arrives while an earlier one is still waiting out its delay replaces it. Only the later strobe starts a cycle, with the later strobe's delay and bunch-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one data word per wire per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 10*CHANNELS | One 10-bit word per wire; wire c in bits 10c+9:10c, bit 9 earliest |
| xing_i | input | 1 | Bunch-crossing strobe, one clock wide |
| bz_i | input | 1 | Bunch-zero flag, sampled with the crossing strobe |
| start_dly_i | input | DLY_W | Ticks from crossing strobe to word 0, sampled with the strobe |
| tbl_we_i | input | 1 | Table or mask write enable |
| tbl_addr_i | input | 6 | Row (0-32) or mask (33-38) address |
| tbl_data_i | input | 22 | Row enables, or mask in bits 10:0 |
| trig_word_o | output | 16 | Trigger frame word |
| word_valid_o | output | 1 | A frame word is present |
| word0_o | output | 1 | First word of a frame |
| bz_mark_o | output | 1 | Frame belongs to a bunch-zero crossing |
| strobe_o | output | 1 | Data strobe at half the word rate |

## Verification
The hardest case to reach from the ports is the one that decides R10 and R2 together. Here a hit for the last tick of one cycle depends on a word that is at the same time word 0 of the next cycle. That same edge also has to close the old windows and start the new ones. The stimulus places two crossings exactly 33 ticks apart and lays pulses across that shared word. It also places a four-bit pulse that straddles words 32 and 33 of an isolated cycle. A second strobe sent during a pending delay exercises the replacement rule. The bench checks it through both the frame timing and the bunch-zero marker.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int WORD_W  = 10;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SEG_W   = 2 * WORD_W;
    localparam int RUN_LEN = 4;
    localparam int N_WIN   = 11;
    localparam int ROW_W   = 2 * N_WIN;
    localparam int N_TRIG  = 6;
    localparam int TRIG_IW = $clog2(N_TRIG);
    localparam int N_TICK  = 33;
    localparam int OUT_W   = 16;
    localparam int ADDR_W  = 6;
endpackage

// File: rtl/tw_hit_scan.sv
module tw_hit_scan
    import tw_pkg::*;
(
    input  logic [WORD_W-1:0] prev_i,
    input  logic [WORD_W-1:0] cur_i,
    output logic              early_o,
    output logic              late_o
);
    logic [SEG_W-1:0] seg;
    logic             run;

    // offset o counts from the earliest sample of the older word
    always_comb begin
        seg     = {prev_i, cur_i};
        early_o = 1'b0;
        late_o  = 1'b0;
        run     = 1'b0;
        for (int o = 0; o < WORD_W; o++) begin
            run = 1'b1;
            for (int b = 0; b < RUN_LEN; b++) begin
                run = run & seg[SEG_W-1-o-b];
            end
            if (o < HALF_W) early_o = early_o | run;
            else            late_o  = late_o | run;
        end
    end
endmodule

// File: rtl/tw_chan.sv
module tw_chan
    import tw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W-1:0]             cur_i,
    input  logic                          eval_i,
    input  logic                          last_i,
    input  logic [ROW_W-1:0]              row_i,
    input  logic [N_TRIG-1:0][N_WIN-1:0]  mask_i,
    output logic [N_TRIG-1:0]             trig_o
);
    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic [N_WIN-1:0]  win;
    } chan_st_t;

    chan_st_t         s_q, s_d;
    logic             early, late;
    logic [N_WIN-1:0] hit_win, fin_win;

    tw_hit_scan u_scan (
        .prev_i  (s_q.prev),
        .cur_i   (cur_i),
        .early_o (early),
        .late_o  (late)
    );

    always_comb begin
        for (int i = 0; i < N_WIN; i++) begin
            hit_win[i] = eval_i & ((early & row_i[2*i]) | (late & row_i[2*i+1]));
        end
        fin_win = s_q.win | hit_win;
        for (int j = 0; j < N_TRIG; j++) begin
            trig_o[j] = |(fin_win & mask_i[j]);
        end
        s_d      = s_q;
        s_d.prev = cur_i;
        s_d.win  = last_i ? '0 : fin_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xing_i,
    input  logic                          bz_i,
    input  logic [DLY_W-1:0]              dly_i,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [ROW_W-1:0]              data_i,
    output logic                          eval_o,
    output logic                          last_o,
    output logic [ROW_W-1:0]              row_o,
    output logic [N_TRIG-1:0][N_WIN-1:0]  mask_o,
    output logic                          bz_o
);
    localparam logic [ADDR_W-1:0] LAST_PH  = ADDR_W'(N_TICK - 1);
    localparam logic [ADDR_W-1:0] TBL_END  = ADDR_W'(N_TICK);
    localparam logic [ADDR_W-1:0] MASK_END = ADDR_W'(N_TICK + N_TRIG);

    typedef struct packed {
        logic [N_TICK-1:0][ROW_W-1:0] tbl;
        logic [N_TRIG-1:0][N_WIN-1:0] mask;
        logic                         armed;
        logic [DLY_W-1:0]             dly;
        logic                         act;
        logic [ADDR_W-1:0]            ph;
        logic                         bzp;
        logic                         bzc;
    } seq_st_t;

    seq_st_t             s_q, s_d;
    logic                start;
    logic [TRIG_IW-1:0]  midx;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        midx  = TRIG_IW'(addr_i - TBL_END);

        if (we_i) begin
            if (addr_i < TBL_END)       s_d.tbl[addr_i] = data_i;
            else if (addr_i < MASK_END) s_d.mask[midx]  = data_i[N_WIN-1:0];
        end

        // a fresh strobe always overrides a pending one
        if (xing_i) begin
            s_d.bzp   = bz_i;
            s_d.dly   = dly_i;
            s_d.armed = (dly_i != '0);
            start     = (dly_i == '0);
        end else if (s_q.armed) begin
            s_d.dly = s_q.dly - DLY_W'(1);
            if (s_q.dly == DLY_W'(1)) begin
                s_d.armed = 1'b0;
                start     = 1'b1;
            end
        end

        if (s_q.act) begin
            if (s_q.ph == LAST_PH) s_d.act = 1'b0;
            else                   s_d.ph  = s_q.ph + ADDR_W'(1);
        end

        if (start) begin
            s_d.act = 1'b1;
            s_d.ph  = '0;
            s_d.bzc = xing_i ? bz_i : s_q.bzp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign eval_o = s_q.act;
    assign last_o = s_q.act && (s_q.ph == LAST_PH);
    assign row_o  = s_q.tbl[s_q.ph];
    assign mask_o = s_q.mask;
    assign bz_o   = s_q.bzc;
endmodule

// File: rtl/tw_out_mux.sv
module tw_out_mux
    import tw_pkg::*;
#(
    parameter int CHANNELS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [CHANNELS*N_TRIG-1:0]   frame_i,
    input  logic                         bz_i,
    output logic [OUT_W-1:0]             word_o,
    output logic                         valid_o,
    output logic                         word0_o,
    output logic                         strobe_o,
    output logic                         bz_o
);
    localparam int FRAME_W = CHANNELS * N_TRIG;
    localparam int NWORDS  = (FRAME_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W   = NWORDS * OUT_W;
    localparam int IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    typedef struct packed {
        logic [NWORDS-1:0][OUT_W-1:0] words;
        logic                         busy;
        logic [IDX_W-1:0]             idx;
        logic                         bz;
    } mux_st_t;

    mux_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.idx == LAST_IDX) s_d.busy = 1'b0;
            else                     s_d.idx  = s_q.idx + IDX_W'(1);
        end
        if (load_i) begin
            s_d.words = PAD_W'(frame_i);
            s_d.busy  = 1'b1;
            s_d.idx   = '0;
            s_d.bz    = bz_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o   = s_q.busy ? s_q.words[s_q.idx] : '0;
    assign valid_o  = s_q.busy;
    assign word0_o  = s_q.busy && (s_q.idx == '0);
    assign strobe_o = s_q.busy && !s_q.idx[0];
    assign bz_o     = s_q.busy && s_q.bz;
endmodule

// File: rtl/tw_occ_trigger.sv
module tw_occ_trigger
    import tw_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int DLY_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CHANNELS*WORD_W-1:0] word_i,
    input  logic                       xing_i,
    input  logic                       bz_i,
    input  logic [DLY_W-1:0]           start_dly_i,
    input  logic                       tbl_we_i,
    input  logic [ADDR_W-1:0]          tbl_addr_i,
    input  logic [ROW_W-1:0]           tbl_data_i,
    output logic [OUT_W-1:0]           trig_word_o,
    output logic                       word_valid_o,
    output logic                       word0_o,
    output logic                       bz_mark_o,
    output logic                       strobe_o
);
    localparam int FRAME_W = CHANNELS * N_TRIG;

    logic                          seq_eval;
    logic                          seq_last;
    logic [ROW_W-1:0]              seq_row;
    logic [N_TRIG-1:0][N_WIN-1:0]  seq_mask;
    logic                          seq_bz;
    logic [FRAME_W-1:0]            frame;

    tw_seq #(.DLY_W(DLY_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .xing_i (xing_i),
        .bz_i   (bz_i),
        .dly_i  (start_dly_i),
        .we_i   (tbl_we_i),
        .addr_i (tbl_addr_i),
        .data_i (tbl_data_i),
        .eval_o (seq_eval),
        .last_o (seq_last),
        .row_o  (seq_row),
        .mask_o (seq_mask),
        .bz_o   (seq_bz)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        tw_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur_i  (word_i[c*WORD_W +: WORD_W]),
            .eval_i (seq_eval),
            .last_i (seq_last),
            .row_i  (seq_row),
            .mask_i (seq_mask),
            .trig_o (frame[c*N_TRIG +: N_TRIG])
        );
    end

    tw_out_mux #(.CHANNELS(CHANNELS)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (seq_last),
        .frame_i  (frame),
        .bz_i     (seq_bz),
        .word_o   (trig_word_o),
        .valid_o  (word_valid_o),
        .word0_o  (word0_o),
        .strobe_o (strobe_o),
        .bz_o     (bz_mark_o)
    );
endmodule

// File: rtl/tw_occ_trigger_chk.sv
module tw_occ_trigger_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        last_i,
    input logic        valid_i,
    input logic        word0_i,
    input logic        strobe_i,
    input logic        bzm_i,
    input logic [15:0] word_i
);
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> (valid_i && word0_i));                                   // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (word_i == 16'h0 && !word0_i && !strobe_i && !bzm_i)); // R11

    AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        word0_i |-> strobe_i);                                              // R9

    AST_STROBE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !word0_i) |-> (strobe_i != $past(strobe_i)));           // R9

    AST_BZ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !word0_i) |-> $stable(bzm_i));                          // R9
endmodule

bind tw_occ_trigger tw_occ_trigger_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_i   (seq_last),
    .valid_i  (word_valid_o),
    .word0_i  (word0_o),
    .strobe_i (strobe_o),
    .bzm_i    (bz_mark_o),
    .word_i   (trig_word_o)
);

// File: tb/sim_tw_occ_trigger.sv
module sim_tw_occ_trigger;
    localparam int CH = 4;
    localparam int DW = 6;
    localparam int NW = 2;
    localparam int MAXC = 700;
    localparam int TICKS = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [CH*10-1:0] word;
    logic xing, bz, we;
    logic [DW-1:0] dly;
    logic [5:0] addr;
    logic [21:0] wdata;
    logic [15:0] trig_word_o;
    logic word_valid_o, word0_o, bz_mark_o, strobe_o;

    tw_occ_trigger #(.CHANNELS(CH), .DLY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .word_i(word), .xing_i(xing), .bz_i(bz),
        .start_dly_i(dly), .tbl_we_i(we), .tbl_addr_i(addr), .tbl_data_i(wdata),
        .trig_word_o(trig_word_o), .word_valid_o(word_valid_o), .word0_o(word0_o),
        .bz_mark_o(bz_mark_o), .strobe_o(strobe_o)
    );

    logic [9:0] sw [MAXC][CH];
    bit sx [MAXC];
    bit sb [MAXC];
    int sd [MAXC];
    logic [21:0] mtbl [TICKS];
    logic [10:0] mmask [6];
    int xa [16];
    int xdl [16];
    bit xbz [16];
    int nx = 0;

    typedef struct {
        logic [15:0] w;
        bit f;
        bit st;
        bit b;
        int cyc;
    } exp_t;
    exp_t q[$];

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as frame words appear
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (word_valid_o) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7 R12", "unexpected frame word", 32'(trig_word_o), 0);
                end else begin
                    e = q.pop_front();
                    chk(trig_word_o == e.w, "R8", "frame word", 32'(trig_word_o), 32'(e.w));
                    chk({word0_o, strobe_o, bz_mark_o} == {e.f, e.st, e.b}, "R9",
                        "first/strobe/bz markers", 32'({word0_o, strobe_o, bz_mark_o}),
                        32'({e.f, e.st, e.b}));
                    if (e.f) chk(cyc == e.cyc, "R5 R7", "first word cycle", cyc, e.cyc);
                end
            end else begin
                chk(trig_word_o == 16'h0 && !word0_o && !strobe_o && !bz_mark_o, "R11",
                    "idle outputs", 32'({trig_word_o, word0_o, strobe_o, bz_mark_o}), 0);
            end
        end
    end

    task automatic play(int upto);
        while (cyc < upto) begin
            @(negedge clk);
            for (int c = 0; c < CH; c++) word[c*10 +: 10] = sw[cyc][c];
            xing = sx[cyc];
            bz = sb[cyc];
            dly = DW'(sd[cyc]);
        end
        @(negedge clk);
        word = '0; xing = 1'b0; bz = 1'b0; dly = '0;
    endtask

    task automatic twrite(int a, logic [21:0] d);
        @(negedge clk);
        we = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic put_pulse(int wbase, int off, int width, int c);
        for (int t = 0; t < width; t++) begin
            int p;
            p = off + t;
            sw[wbase + p / 10][c][9 - p % 10] = 1'b1;
        end
    endtask

    task automatic plan(int a, int d, bit b);
        sx[a] = 1'b1; sb[a] = b; sd[a] = d;
        xa[nx] = a; xdl[nx] = d; xbz[nx] = b;
        nx++;
    endtask

    task automatic rand_pulses(int wbase, int seed);
        int unsigned r;
        r = seed;
        for (int c = 0; c < CH; c++) begin
            for (int n = 0; n < 3; n++) begin
                int st, wd;
                r = r * 1103515245 + 12345;
                st = int'((r >> 8) % 330);
                r = r * 1103515245 + 12345;
                wd = 3 + int'((r >> 8) % 5);
                put_pulse(wbase, st, wd, c);
            end
        end
    endtask

    function automatic bit run4(logic [19:0] s, int from, int to);
        for (int o = from; o <= to; o++) begin
            if (s[19-o] && s[18-o] && s[17-o] && s[16-o]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [21:0] row_of(int k);
        logic [21:0] r;
        int i;
        r = '0;
        i = k / 3;
        if (i < 11) begin
            if (k % 3 != 2) r[2*i] = 1'b1;
            if (k % 3 != 0) r[2*i+1] = 1'b1;
        end
        return r;
    endfunction

    // independent model of R2, R3, R6, R8, R9, R5/R7 timing
    task automatic expect_all();
        for (int x = 0; x < nx; x++) begin
            logic [31:0] fr;
            int b;
            fr = '0;
            b = xa[x] + xdl[x];
            for (int c = 0; c < CH; c++) begin
                logic [10:0] win;
                win = '0;
                for (int k = 0; k < TICKS; k++) begin
                    logic [19:0] seg;
                    bit e, l;
                    seg = {sw[b+k][c], sw[b+k+1][c]};
                    e = run4(seg, 0, 4);
                    l = run4(seg, 5, 9);
                    for (int i = 0; i < 11; i++) begin
                        if ((e && mtbl[k][2*i]) || (l && mtbl[k][2*i+1])) win[i] = 1'b1;
                    end
                end
                for (int j = 0; j < 6; j++) fr[c*6+j] = |(win & mmask[j]);
            end
            for (int w = 0; w < NW; w++) begin
                exp_t e;
                e.w = fr[16*w +: 16];
                e.f = (w == 0);
                e.st = (w % 2 == 0);
                e.b = xbz[x];
                e.cyc = b + 34 + w;
                q.push_back(e);
            end
        end
        nx = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        logic [10:0] masks [6];
        masks = '{11'h003, 11'h00C, 11'h070, 11'h380, 11'h400, 11'h7FF};
        for (int i = 0; i < MAXC; i++) begin
            sx[i] = 1'b0; sb[i] = 1'b0; sd[i] = 0;
            for (int c = 0; c < CH; c++) sw[i][c] = '0;
        end
        for (int k = 0; k < TICKS; k++) mtbl[k] = '0;
        for (int j = 0; j < 6; j++) mmask[j] = '0;
        word = '0; xing = 1'b0; bz = 1'b0; dly = '0; we = 1'b0; addr = '0; wdata = '0;

        repeat (3) @(negedge clk);
        chk(trig_word_o == 16'h0 && !word_valid_o && !word0_o && !bz_mark_o && !strobe_o,
            "R1", "outputs in reset", 32'({trig_word_o, word_valid_o, word0_o, bz_mark_o, strobe_o}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: unprogrammed table and masks give an all-zero frame even on solid input
        base = cyc + 3;
        plan(base, 2, 1'b1);
        for (int k = 0; k < 34; k++)
            for (int c = 0; c < CH; c++) sw[base+2+k][c] = 10'h3FF;
        expect_all();
        play(base + 2 + 34 + NW + 3);
        chk(q.size() == 0, "R1", "frames pending after zero-table run", q.size(), 0);

        // R4: program rows and masks; addresses 39 and 63 must have no effect
        for (int k = 0; k < TICKS; k++) begin
            twrite(k, row_of(k));
            mtbl[k] = row_of(k);
        end
        for (int j = 0; j < 6; j++) begin
            twrite(33 + j, {11'h0, masks[j]});
            mmask[j] = masks[j];
        end
        twrite(39, 22'h3FFFFF);
        twrite(63, 22'h3FFFFF);

        base = cyc + 3;
        plan(base, 3, 1'b1);                 // R2 R3 R6: random pulses
        rand_pulses(base + 3, 7);
        plan(base + 60, 0, 1'b0);            // R2 corner pulses
        put_pulse(base + 60, 52, 3, 0);      // three ones only: no hit
        put_pulse(base + 60, 75, 4, 1);      // exact four, late half
        put_pulse(base + 60, 128, 4, 2);     // straddles words 12 and 13
        put_pulse(base + 60, 329, 4, 3);     // word 32 tail into word 33
        plan(base + 120, 1, 1'b1);           // R10 back-to-back pair
        rand_pulses(base + 121, 21);
        plan(base + 153, 1, 1'b0);
        rand_pulses(base + 154, 33);
        sx[base + 200] = 1'b1;               // R12: pending strobe later replaced
        sd[base + 200] = 5;
        sb[base + 200] = 1'b1;
        plan(base + 202, 1, 1'b0);
        rand_pulses(base + 203, 45);
        expect_all();
        play(base + 300);
        chk(q.size() == 0, "R10 R12", "frames pending after sequence", q.size(), 0);

        // R4 R6: rewrite one mask and row 0, then run again
        twrite(36, 22'h0007FF);
        mmask[3] = 11'h7FF;
        twrite(0, 22'h155555);
        mtbl[0] = 22'h155555;
        base = cyc + 3;
        plan(base, 4, 1'b0);
        rand_pulses(base + 4, 99);
        put_pulse(base + 4, 0, 5, 1);
        expect_all();
        play(base + 4 + 34 + NW + 3);
        chk(q.size() == 0, "R4 R6", "frames pending after reprogramming", q.size(), 0);

        mon_on = 1'b0;
        finish_run();
    end
endmodule